// File: doc/BRIEF.md
# Linked-Descriptor DMA Engine for a Storage-Card Host

This block moves data between system memory and the data FIFO of a storage-card host controller. Software does not give it one address and length. It builds a linked chain of descriptors in memory and hands the engine the address of the first one. Each descriptor is four 32-bit words: a control word, a byte count, the address of the data buffer, and a link to the next descriptor. The engine walks the chain. For each descriptor it checks that the descriptor has been handed over to it. It then moves the counted bytes in the selected direction, rewrites the control word to hand the descriptor back, and follows the link. It stops after the descriptor marked as the end of the chain.

The engine starts on a one-cycle start pulse. That pulse is accepted only while two enable inputs are both high. The overall transfer length (block size times block count) comes in on its own input and caps the bytes moved across the whole chain. A burst-mode input chooses between moving a word whenever the FIFO can take or give one, and waiting until a whole burst fits. At the end of a chain the engine gives a one-cycle done pulse. When it meets a descriptor it may not use, it stops and reports an error code instead.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, memReq, fifoPush, fifoPop and done are low, and errCode is 0.
- R2: A start pulse is ignored unless dmaEn and intDmaEn are both high. An ignored start makes no memory request and produces no done pulse.
- R3: The engine fetches the four descriptor words from the descriptor address plus 0, 4, 8 and 12. Word 0 holds the control bits: hand-over bit 31, link-valid bit 4, first-segment bit 3, end-of-chain bit 2. The low 16 bits of word 1 are the byte count. Word 2 is the buffer address and word 3 is the link.
- R4: A descriptor with bit 31 clear ends the run with errCode 1: no data is moved and there is no writeback. A first descriptor without bit 3 ends the run with errCode 2. A new accepted start clears errCode.
- R5: With dirToMem low, the engine reads ceil(bytes/4) words from the buffer at ascending addresses and pushes each word, in that order, into the FIFO.
- R6: With dirToMem high, the engine pops ceil(bytes/4) words from the FIFO and writes them to the buffer at ascending addresses. No word beyond that count is written.
- R7: After a descriptor's data has moved, the engine writes word 0 back to the descriptor address with bit 31 cleared and every other bit unchanged.
- R8: If bit 4 is set, the next descriptor is read from the word 3 address. If bit 4 is clear, it is read from the current descriptor address plus 16.
- R9: After the writeback of a descriptor with bit 2 set, done pulses high for one cycle. The engine then makes no further memory request.
- R10: A descriptor whose byte count is zero causes no FIFO push or pop. It is still written back and the chain is still followed.
- R11: Each descriptor moves min(byte count, remaining total) bytes, with the remaining total starting at totalBytes. Once that total is used up, later descriptors move no data but are still written back.
- R12: The engine never pushes while fifoRoom is 0 and never pops while fifoFill is 0. With fixedBurst high, a burst starts only when the FIFO level is at least min(4, words left in the descriptor). With fixedBurst low, one word is enough.
- R13: Once memReq is raised, it stays high with a stable memAddr until the cycle in which memAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse |
| baseAddr | input | 32 | Address of the first descriptor |
| totalBytes | input | 20 | Total transfer length in bytes |
| dmaEn | input | 1 | DMA enable |
| intDmaEn | input | 1 | Descriptor engine enable |
| fixedBurst | input | 1 | Wait for whole bursts before moving data |
| dirToMem | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memAck is high |
| memAck | input | 1 | Access completes this cycle |
| fifoPush | output | 1 | Push memRdata into the FIFO |
| fifoPushData | output | 32 | Data pushed into the FIFO |
| fifoRoom | input | 8 | Free FIFO entries |
| fifoPop | output | 1 | Pop the FIFO head |
| fifoPopData | input | 32 | Current FIFO head word |
| fifoFill | input | 8 | Occupied FIFO entries |
| done | output | 1 | One-cycle pulse at the end of a chain |
| errCode | output | 2 | 0 none, 1 descriptor not handed over, 2 first segment missing |

## Verification
The assertions take four things for granted about the inputs. The memory holds memAck for a single cycle, only in answer to a pending request. The FIFO head word stays put until it is popped. The FIFO levels report real occupancy. dirToMem, fixedBurst and totalBytes stay constant while a chain runs. The bench meets all four with models built for the purpose. Its memory acknowledges one cycle after the request and its FIFO counts every push and pop. It changes the mode inputs only while the engine is idle, and it moves the FIFO room limit only to open or close a stall window.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  // control word bit positions, decoded from descriptors built by software
  localparam int OWN_BIT = 31;
  localparam int CH_BIT  = 4;
  localparam int FS_BIT  = 3;
  localparam int LD_BIT  = 2;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_UNAVAIL  = 2'd1,
    ERR_NO_FIRST = 2'd2
  } err_e;

  typedef enum logic {
    SEL_DESC = 1'b0,
    SEL_BUF  = 1'b1
  } addr_sel_e;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic      loadBase;
    logic      latchWord;
    logic      setupSeg;
    logic      startBurst;
    logic      wordDone;
    logic      advance;
    logic      wbSel;
    addr_sel_e addrSel;
  } dp_ctrl_t;
endpackage

// File: rtl/desc_dma_dpath.sv
module desc_dma_dpath
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int TOT_W       = 20,
  parameter int BURST_WORDS = 4,
  parameter int LVL_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [TOT_W-1:0]  totalBytes,
  input  logic              dirToMem,
  input  logic              fixedBurst,
  input  logic [31:0]       memRdata,
  input  logic [31:0]       fifoData,
  input  logic [LVL_W-1:0]  fifoRoom,
  input  logic [LVL_W-1:0]  fifoFill,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              flagOwn,
  output logic              flagFs,
  output logic              flagLd,
  output logic              fetchLast,
  output logic              segEmptyNext,
  output logic              lastWord,
  output logic              burstIdle,
  output logic              gateOk
);
  localparam int BL_W = $clog2(BURST_WORDS + 1);
  localparam int NWORDS = 4;

  logic [ADDR_W-1:0] descAddr;
  logic [ADDR_W-1:0] bufAddr;
  logic [1:0]        fetchIdx;
  logic [31:0]       descWord [NWORDS];
  logic [TOT_W-1:0]  remBytes;
  logic [TOT_W-1:0]  wordsLeft;
  logic [BL_W-1:0]   burstLeft;

  logic [TOT_W-1:0]  cntExt;
  logic [TOT_W-1:0]  segBytes;
  logic [TOT_W:0]    roundUp;
  logic [TOT_W-1:0]  segWords;
  logic [TOT_W-1:0]  needCnt;
  logic [LVL_W-1:0]  level;
  logic              flagCh;

  always_comb begin
    cntExt   = TOT_W'(descWord[1][CNT_W-1:0]);
    segBytes = (cntExt > remBytes) ? remBytes : cntExt;
    roundUp  = {1'b0, segBytes} + (TOT_W+1)'(3);
    segWords = TOT_W'(roundUp >> 2);
    if (fixedBurst)
      needCnt = (wordsLeft < TOT_W'(BURST_WORDS)) ? wordsLeft : TOT_W'(BURST_WORDS);
    else
      needCnt = TOT_W'(1);
    level  = dirToMem ? fifoFill : fifoRoom;
    gateOk = (wordsLeft != '0) && (TOT_W'(level) >= needCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr  <= '0;
      bufAddr   <= '0;
      fetchIdx  <= '0;
      remBytes  <= '0;
      wordsLeft <= '0;
      burstLeft <= '0;
      for (int i = 0; i < NWORDS; i++) descWord[i] <= '0;
    end else begin
      if (ctl.loadBase) begin
        descAddr <= baseAddr;
        remBytes <= totalBytes;
        fetchIdx <= '0;
      end
      if (ctl.latchWord) begin
        descWord[fetchIdx] <= memRdata;
        fetchIdx           <= fetchIdx + 2'd1;
      end
      if (ctl.setupSeg) begin
        wordsLeft <= segWords;
        remBytes  <= remBytes - segBytes;
        bufAddr   <= descWord[2][ADDR_W-1:0];
        burstLeft <= '0;
      end
      if (ctl.startBurst) burstLeft <= BL_W'(needCnt);
      if (ctl.wordDone) begin
        bufAddr   <= bufAddr + ADDR_W'(4);
        wordsLeft <= wordsLeft - TOT_W'(1);
        burstLeft <= burstLeft - BL_W'(1);
      end
      if (ctl.advance) begin
        descAddr <= flagCh ? descWord[3][ADDR_W-1:0] : descAddr + ADDR_W'(16);
        fetchIdx <= '0;
      end
    end
  end

  // fetchIdx wraps to zero after the fourth word, so writeback lands on word 0
  assign memAddr  = (ctl.addrSel == SEL_DESC) ? descAddr + ADDR_W'({fetchIdx, 2'b00}) : bufAddr;
  assign memWdata = ctl.wbSel ? (descWord[0] & ~(32'd1 << OWN_BIT)) : fifoData;

  assign flagOwn      = descWord[0][OWN_BIT];
  assign flagCh       = descWord[0][CH_BIT];
  assign flagFs       = descWord[0][FS_BIT];
  assign flagLd       = descWord[0][LD_BIT];
  assign fetchLast    = (fetchIdx == 2'd3);
  assign segEmptyNext = (segBytes == '0);
  assign lastWord     = (wordsLeft == TOT_W'(1));
  assign burstIdle    = (burstLeft == '0);

  // R11: a word is never moved past the segment length
  a_r11_words_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wordDone |-> (wordsLeft != '0));
  // R11: the remaining total only shrinks
  a_r11_rem_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setupSeg |=> (remBytes <= $past(remBytes)));
  // R12: a burst never runs beyond the words left
  a_r12_burst_within_seg: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wordDone |-> (TOT_W'(burstLeft) <= wordsLeft));
endmodule

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     dmaEn,
  input  logic     intDmaEn,
  input  logic     dirToMem,
  input  logic     memAck,
  input  logic     flagOwn,
  input  logic     flagFs,
  input  logic     flagLd,
  input  logic     fetchLast,
  input  logic     segEmptyNext,
  input  logic     lastWord,
  input  logic     burstIdle,
  input  logic     gateOk,
  output dp_ctrl_t ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     pushStb,
  output logic     popStb,
  output logic     done,
  output err_e     errCode
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER, ST_WB
  } state_e;

  state_e state, stateNext;
  logic   firstSeg;
  logic   doneSet;
  err_e   errSet;
  logic   errLoad;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    pushStb   = 1'b0;
    popStb    = 1'b0;
    doneSet   = 1'b0;
    errSet    = ERR_NONE;
    errLoad   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start && dmaEn && intDmaEn) begin
          ctl.loadBase = 1'b1;
          errLoad      = 1'b1;
          stateNext    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_DESC;
        if (memAck) begin
          ctl.latchWord = 1'b1;
          if (fetchLast) stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!flagOwn) begin
          errSet    = ERR_UNAVAIL;
          errLoad   = 1'b1;
          stateNext = ST_IDLE;
        end else if (firstSeg && !flagFs) begin
          errSet    = ERR_NO_FIRST;
          errLoad   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.setupSeg = 1'b1;
          stateNext    = segEmptyNext ? ST_WB : ST_XFER;
        end
      end
      ST_XFER: begin
        ctl.addrSel = SEL_BUF;
        if (burstIdle) begin
          if (gateOk) ctl.startBurst = 1'b1;
        end else begin
          memReq = 1'b1;
          memWe  = dirToMem;
          if (memAck) begin
            ctl.wordDone = 1'b1;
            pushStb      = !dirToMem;
            popStb       = dirToMem;
            if (lastWord) stateNext = ST_WB;
          end
        end
      end
      ST_WB: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = SEL_DESC;
        ctl.wbSel   = 1'b1;
        if (memAck) begin
          if (flagLd) begin
            doneSet   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      firstSeg <= 1'b0;
      done     <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      state <= stateNext;
      done  <= doneSet;
      if (errLoad) errCode <= errSet;
      if (ctl.loadBase) firstSeg <= 1'b1;
      else if (ctl.advance) firstSeg <= 1'b0;
    end
  end

  // R13: a pending request holds until acknowledged
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R9: nothing is requested once the chain has ended
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memReq && errCode == ERR_NONE));
  // R4: an error stops memory traffic
  a_r4_error_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCode != ERR_NONE) |-> !memReq);
  // R10: FIFO strobes are exclusive
  a_r10_one_fifo_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(pushStb && popStb));
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int TOT_W       = 20,
  parameter int BURST_WORDS = 4,
  parameter int LVL_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [TOT_W-1:0]  totalBytes,
  input  logic              dmaEn,
  input  logic              intDmaEn,
  input  logic              fixedBurst,
  input  logic              dirToMem,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              fifoPush,
  output logic [31:0]       fifoPushData,
  input  logic [LVL_W-1:0]  fifoRoom,
  output logic              fifoPop,
  input  logic [31:0]       fifoPopData,
  input  logic [LVL_W-1:0]  fifoFill,
  output logic              done,
  output logic [1:0]        errCode
);
  dp_ctrl_t ctl;
  err_e     errState;
  logic     flagOwn, flagFs, flagLd, fetchLast, segEmptyNext;
  logic     lastWord, burstIdle, gateOk;

  desc_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dmaEn(dmaEn), .intDmaEn(intDmaEn),
    .dirToMem(dirToMem), .memAck(memAck), .flagOwn(flagOwn), .flagFs(flagFs),
    .flagLd(flagLd), .fetchLast(fetchLast), .segEmptyNext(segEmptyNext),
    .lastWord(lastWord), .burstIdle(burstIdle), .gateOk(gateOk), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .pushStb(fifoPush), .popStb(fifoPop),
    .done(done), .errCode(errState)
  );

  desc_dma_dpath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TOT_W(TOT_W),
    .BURST_WORDS(BURST_WORDS), .LVL_W(LVL_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseAddr(baseAddr), .totalBytes(totalBytes),
    .dirToMem(dirToMem), .fixedBurst(fixedBurst), .memRdata(memRdata),
    .fifoData(fifoPopData), .fifoRoom(fifoRoom), .fifoFill(fifoFill),
    .memAddr(memAddr), .memWdata(memWdata), .flagOwn(flagOwn), .flagFs(flagFs),
    .flagLd(flagLd), .fetchLast(fetchLast), .segEmptyNext(segEmptyNext),
    .lastWord(lastWord), .burstIdle(burstIdle), .gateOk(gateOk)
  );

  assign fifoPushData = memRdata;
  assign errCode      = errState;

  // R12: flow control at the FIFO edge
  a_r12_push_room: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> (fifoRoom != '0));
  a_r12_pop_fill: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoFill != '0));
  // R13: the address of a pending request does not move
  a_r13_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));
  // R6: a FIFO word is only consumed by a completed memory write
  a_r6_pop_with_write: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (memAck && memWe));
endmodule

// File: tb/test_desc_chain_dma.sv
module test_desc_chain_dma;
  localparam int OWN = 32'h8000_0000;
  localparam int CHF = 32'h10;
  localparam int FSF = 32'h08;
  localparam int LDF = 32'h04;
  localparam int XTRA = 32'h40;

  logic clk = 0, rstN = 0;
  logic start = 0, dmaEn = 0, intDmaEn = 0, fixedBurst = 0, dirToMem = 0;
  logic [31:0] baseAddr = 0;
  logic [19:0] totalBytes = 0;
  logic memReq, memWe, memAck = 0, fifoPush, fifoPop, done;
  logic [31:0] memAddr, memWdata, memRdata, fifoPushData, fifoPopData;
  logic [7:0] fifoRoom, fifoFill;
  logic [1:0] errCode;

  logic [31:0] mem [0:1023];
  logic [31:0] fifo [0:63];
  int wp = 0, rp = 0, roomCap = 64;
  int doneCnt = 0, reqCnt = 0, holdViol = 0, flowViol = 0;
  logic prevPend = 0;
  logic [31:0] prevAddr = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  desc_chain_dma i_desc_chain_dma (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .totalBytes(totalBytes),
    .dmaEn(dmaEn), .intDmaEn(intDmaEn), .fixedBurst(fixedBurst), .dirToMem(dirToMem),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .fifoPush(fifoPush), .fifoPushData(fifoPushData),
    .fifoRoom(fifoRoom), .fifoPop(fifoPop), .fifoPopData(fifoPopData), .fifoFill(fifoFill),
    .done(done), .errCode(errCode)
  );

  assign memRdata    = mem[memAddr[11:2]];
  assign fifoPopData = fifo[rp % 64];
  assign fifoFill    = 8'(wp - rp);
  assign fifoRoom    = (roomCap > (wp - rp)) ? 8'(roomCap - (wp - rp)) : 8'd0;

  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && memAck && memWe) mem[memAddr[11:2]] <= memWdata;
    if (fifoPush) begin fifo[wp % 64] <= fifoPushData; wp <= wp + 1; end
    if (fifoPop) rp <= rp + 1;
    if ((fifoPush && fifoRoom == 0) || (fifoPop && fifoFill == 0)) flowViol <= flowViol + 1;
    if (prevPend && (!memReq || memAddr != prevAddr)) holdViol <= holdViol + 1;
    prevPend <= memReq && !memAck;
    prevAddr <= memAddr;
    if (done) doneCnt <= doneCnt + 1;
    if (memReq) reqCnt <= reqCnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    wp = 0; rp = 0; doneCnt = 0; reqCnt = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (doneCnt > 0 || errCode != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic runCase(input int n, input bit dir, input bit fx, input bit ch, input int seed, input bit clip);
    int descA[3], bufA[3], bc[3], seg[3], wc[3], flg[3];
    int sum, total, rem, tw, k, bad;
    clearAll();
    sum = 0;
    for (int i = 0; i < n; i++) begin
      descA[i] = ch ? ('h100 + i * 'h30) : ('h40 + i * 16);
      bufA[i]  = 'h800 + i * 'h40;
      bc[i]    = (seed * 5 + i * 11 + 3 * n) % 21;
      flg[i]   = OWN | XTRA | (ch ? CHF : 0) | (i == 0 ? FSF : 0) | (i == n - 1 ? LDF : 0);
      sum += bc[i];
    end
    total = (clip && sum > 5) ? sum - 5 : sum;
    rem = total; tw = 0;
    for (int i = 0; i < n; i++) begin
      seg[i] = (bc[i] < rem) ? bc[i] : rem;
      rem -= seg[i];
      wc[i] = (seg[i] + 3) / 4;
      tw += wc[i];
      mem[descA[i] >> 2]       = flg[i];
      mem[(descA[i] >> 2) + 1] = bc[i];
      mem[(descA[i] >> 2) + 2] = bufA[i];
      mem[(descA[i] >> 2) + 3] = (ch && i < n - 1) ? ('h100 + (i + 1) * 'h30) : 'h3F0;
      if (!dir) for (int j = 0; j < 8; j++) mem[(bufA[i] >> 2) + j] = 'hA000_0000 | (i << 8) | j;
    end
    if (dir) begin
      for (int j = 0; j < tw; j++) fifo[j] = 'hB000_0000 + j;
      wp = tw;
    end
    dirToMem = dir; fixedBurst = fx; baseAddr = descA[0]; totalBytes = 20'(total);
    dmaEn = 1; intDmaEn = 1; roomCap = 64;
    pulseStart();
    waitEnd();
    check(doneCnt == 1, "R9", "done pulses", doneCnt, 1);
    check(errCode == 0, "R9", "no error", errCode, 0);
    for (int i = 0; i < n; i++)
      check(mem[descA[i] >> 2] == (flg[i] & ~OWN), "R7", "writeback word (R3 R8 chain walk)",
            mem[descA[i] >> 2], flg[i] & ~OWN);
    bad = 0; k = 0;
    if (!dir) begin
      for (int i = 0; i < n; i++)
        for (int j = 0; j < wc[i]; j++) begin
          if (fifo[k % 64] != ('hA000_0000 | (i << 8) | j)) bad++;
          k++;
        end
      check(wp == tw, "R5", "pushed word count (R11 clip)", wp, tw);
      check(bad == 0, "R5", "pushed word mismatches", bad, 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        for (int j = 0; j < wc[i]; j++) begin
          if (mem[(bufA[i] >> 2) + j] != 'hB000_0000 + k) bad++;
          k++;
        end
        if (mem[(bufA[i] >> 2) + wc[i]] != 0) bad++;
      end
      check(rp == tw, "R6", "popped word count (R11 clip)", rp, tw);
      check(bad == 0, "R6", "buffer word mismatches", bad, 0);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        finishRun();
      end
    end
  end

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    check(memReq == 0 && fifoPush == 0 && fifoPop == 0, "R1", "idle strobes", memReq, 0);
    check(done == 0 && errCode == 0, "R1", "done/err at reset", errCode, 0);
    rstN = 1;
    @(negedge clk);

    // R2: start ignored unless both enables are high
    mem['h10] = OWN | FSF | LDF; mem['h11] = 8; mem['h12] = 'h800;
    baseAddr = 'h40; totalBytes = 8;
    dmaEn = 0; intDmaEn = 1; pulseStart(); repeat (20) @(negedge clk);
    check(reqCnt == 0 && doneCnt == 0, "R2", "dmaEn low, requests", reqCnt, 0);
    dmaEn = 1; intDmaEn = 0; pulseStart(); repeat (20) @(negedge clk);
    check(reqCnt == 0 && doneCnt == 0, "R2", "intDmaEn low, requests", reqCnt, 0);

    // R4: descriptor not handed over
    clearAll();
    mem['h10] = FSF | LDF; mem['h11] = 8; mem['h12] = 'h800; mem['h200] = 'h1234;
    dmaEn = 1; intDmaEn = 1; dirToMem = 0; fixedBurst = 0; baseAddr = 'h40; totalBytes = 8;
    pulseStart(); waitEnd();
    check(errCode == 1, "R4", "unavailable code", errCode, 1);
    check(wp == 0 && doneCnt == 0, "R4", "no data on unavailable", wp, 0);
    check(mem['h10] == (FSF | LDF), "R4", "no writeback", mem['h10], FSF | LDF);

    // R4: first descriptor lacks first-segment bit
    clearAll();
    mem['h10] = OWN | LDF; mem['h11] = 8; mem['h12] = 'h800;
    pulseStart(); waitEnd();
    check(errCode == 2, "R4", "missing first code", errCode, 2);
    check(wp == 0, "R4", "no data on missing first", wp, 0);

    // R4: second link not handed over, first still completes
    clearAll();
    mem['h10] = OWN | FSF; mem['h11] = 8; mem['h12] = 'h800;
    mem['h14] = LDF; mem['h15] = 8; mem['h16] = 'h900;
    mem['h200] = 1; mem['h201] = 2;
    totalBytes = 16; pulseStart(); waitEnd();
    check(errCode == 1, "R4", "second unavailable", errCode, 1);
    check(wp == 2 && mem['h10] == FSF, "R4", "first segment done", wp, 2);

    // R10: zero count descriptor skipped but written back
    clearAll();
    mem['h10] = OWN | FSF | XTRA; mem['h11] = 0; mem['h12] = 'h800;
    mem['h14] = OWN | LDF; mem['h15] = 4; mem['h16] = 'h900; mem['h240] = 'h77;
    dirToMem = 0; totalBytes = 4; pulseStart(); waitEnd();
    check(errCode == 0 && doneCnt == 1, "R10", "chain ends cleanly", errCode, 0);
    check(wp == 1 && fifo[0] == 'h77, "R10", "only second segment pushed", wp, 1);
    check(mem['h10] == (FSF | XTRA), "R10", "zero segment written back", mem['h10], FSF | XTRA);
    check(errCode == 0, "R4", "error cleared by new start", errCode, 0);

    // R12: fixed burst stalls when room is below the burst
    for (int f = 0; f < 2; f++) begin
      clearAll();
      mem['h10] = OWN | FSF | LDF; mem['h11] = 16; mem['h12] = 'h800;
      for (int j = 0; j < 4; j++) mem['h200 + j] = 'hC0 + j;
      dirToMem = 0; fixedBurst = (f == 0); totalBytes = 16; roomCap = 3;
      pulseStart(); repeat (60) @(negedge clk);
      check(wp == (f == 0 ? 0 : 3), "R12", "pushes while room limited", wp, f == 0 ? 0 : 3);
      roomCap = 64; waitEnd();
      check(wp == 4 && doneCnt == 1, "R12", "completes after room opens", wp, 4);
    end

    // near-exhaustive sweep of small chains
    for (int dir = 0; dir < 2; dir++)
      for (int fx = 0; fx < 2; fx++)
        for (int ch = 0; ch < 2; ch++)
          for (int n = 1; n <= 3; n++)
            for (int s = 0; s < 2; s++)
              runCase(n, dir[0], fx[0], ch[0], s + n, s[0]);

    check(flowViol == 0, "R12", "FIFO flow violations", flowViol, 0);
    check(holdViol == 0, "R13", "request hold violations", holdViol, 0);
    finishRun();
  end
endmodule